// File: doc/BRIEF.md
# Three-in-a-Row Ones Detector

This block watches a serial bit stream, one bit per clock, and raises a single-cycle flag on the cycle that brings in the third 1 of an unbroken run. It is a Mealy machine, so the flag depends on the incoming bit in the same cycle and appears before the clock edge that takes that bit in. On that same edge the machine goes back to its idle state. A new detection therefore needs three fresh ones, and matches never overlap: six ones in a row give two flags, on the third and the sixth bit.

A qualifier input marks the cycles that carry a real bit. In a cycle with the qualifier low, the machine keeps its state and drives the flag low. Ones separated only by unqualified cycles therefore still count as consecutive. The state sits in a two-bit register. The next-state and output terms are minimised equations that treat the unused fourth code as a don't-care. From that code the equations still lead to a legal state.

Top module: `ones_run_detect`

## Requirements
- R1: Reset is synchronous and active low. A clock edge with `rst_n` low puts the machine in idle (code 00). After reset, the first two qualified 1s give `hit` = 0.
- R2: A qualified 0 gives `hit` = 0 in its cycle and returns the machine to idle (code 00) from any state, so the run count restarts.
- R3: A qualified 1 moves idle (00) to one-seen (01), and one-seen (01) to two-seen (10). `hit` is 0 in both of these cycles.
- R4: A qualified 1 in two-seen (10) drives `hit` to 1 in that same cycle, and the next state is idle (00). Detections do not overlap: six qualified 1s in a row give `hit` = 1 on the third and sixth bits only.
- R5: `hit` is combinational from the current state and the current inputs. It is 1 only when `bit_vld` = 1, `bit_in` = 1 and state bit 1 is set. Nothing else raises it.
- R6: While `bit_vld` = 0, the state is held and `hit` is 0. A run of 1s interrupted only by unqualified cycles still reaches a detection on its third qualified 1.
- R7: The legal state codes are 00, 01 and 10. Code 11 is never reached from reset. If code 11 is present, the next-state logic goes to 00 on a qualified 0 and to 10 on a qualified 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High in cycles where `bit_in` carries a real bit |
| hit | output | 1 | High in the cycle of the third consecutive qualified 1 |

## Verification
The assertions assume that `bit_in` and `bit_vld` are stable around the rising edge, and that the state register starts from a reset rather than from an arbitrary code. They also assume that no reset edge arrives in the middle of a qualified cycle. The bench changes inputs only at falling edges. It asserts reset with the qualifier held low, so a reset never lands on a cycle that would otherwise report a detection. The unused code cannot be reached through the ports. The bench therefore checks recovery from code 11 on a separate copy of the next-state logic, driven directly.

// File: rtl/ones_run_pkg.sv
// Package: shared state type and codes for the three-ones detector.
// Assumes: a two-bit state with the fixed codes below; code 11 unused.
package ones_run_pkg;
    localparam int STATE_W = 2;

    typedef logic [STATE_W-1:0] state_code_t;

    localparam state_code_t ST_IDLE = 2'b00;  // no ones seen
    localparam state_code_t ST_ONE  = 2'b01;  // one 1 seen
    localparam state_code_t ST_TWO  = 2'b10;  // two 1s seen
    localparam state_code_t ST_BAD  = 2'b11;  // unused code
endpackage

// File: rtl/ones_run_next.sv
// Module: next-state logic from minimised equations (code 11 treated as a don't-care).
// Assumes: cs_i may hold any code; a low qualifier holds the state.
module ones_run_next
    import ones_run_pkg::*;
(
    input  state_code_t cs_i,
    input  logic        din_i,
    input  logic        vld_i,
    output state_code_t ns_o
);
    state_code_t step;

    // Purpose: apply the two next-state equations for a qualified bit.
    always_comb begin
        step[1] = cs_i[0] & din_i;
        step[0] = ~cs_i[1] & ~cs_i[0] & din_i;
    end

    // Purpose: hold the state when the bit is not qualified.
    always_comb begin
        ns_o = vld_i ? step : cs_i;
    end
endmodule

// File: rtl/ones_run_out.sv
// Module: Mealy output logic; the flag follows state bit 1 and the current bit.
// Assumes: the qualifier gates the output in the same cycle.
module ones_run_out
    import ones_run_pkg::*;
(
    input  state_code_t cs_i,
    input  logic        din_i,
    input  logic        vld_i,
    output logic        hit_o
);
    // Purpose: raise the flag only for a qualified 1 in two-seen.
    always_comb begin
        hit_o = vld_i & din_i & cs_i[1];
    end
endmodule

// File: rtl/ones_run_state.sv
// Module: the state register, with a synchronous active-low reset.
// Assumes: RESET_CODE is a legal state code.
module ones_run_state
    import ones_run_pkg::*;
#(
    parameter state_code_t RESET_CODE = ST_IDLE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  state_code_t ns_i,
    output state_code_t cs_o
);
    // Purpose: load the next state each edge, or the reset code while in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_o <= RESET_CODE;
        else        cs_o <= ns_i;
    end
endmodule

// File: rtl/ones_run_detect.sv
// Module: top of the three-consecutive-ones Mealy detector.
// Assumes: inputs are synchronous to clk; a detection returns the machine to idle.
module ones_run_detect
    import ones_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic hit
);
    state_code_t cur_state;
    state_code_t nxt_state;

    ones_run_state #(.RESET_CODE(ST_IDLE)) u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .ns_i  (nxt_state),
        .cs_o  (cur_state)
    );

    ones_run_next u_next (
        .cs_i  (cur_state),
        .din_i (bit_in),
        .vld_i (bit_vld),
        .ns_o  (nxt_state)
    );

    ones_run_out u_out (
        .cs_i  (cur_state),
        .din_i (bit_in),
        .vld_i (bit_vld),
        .hit_o (hit)
    );
endmodule

// File: rtl/ones_run_detect_chk.sv
// Module: property checker for the detector, attached to the top by bind.
// Assumes: the state register starts from reset.
module ones_run_detect_chk
    import ones_run_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bit_in,
    input logic        bit_vld,
    input logic        hit,
    input state_code_t cs
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> cs == ST_IDLE);

    assert_zero_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !bit_in) |=> cs == ST_IDLE);

    assert_first_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && cs == ST_IDLE) |=> cs == ST_ONE);

    assert_second_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && cs == ST_ONE) |=> cs == ST_TWO);

    assert_detect_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && cs == ST_TWO) |-> hit);

    assert_detect_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bit_in && cs == ST_TWO) |=> cs == ST_IDLE);

    assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (bit_vld && bit_in && cs == ST_TWO));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(cs));

    assert_no_flag_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |-> !hit);

    assert_legal_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs != ST_BAD);
endmodule

bind ones_run_detect ones_run_detect_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .hit     (hit),
    .cs      (cur_state)
);

// File: tb/ones_run_detect_tb_top.sv
`timescale 1ns/1ps
module ones_run_detect_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic bit_vld = 1'b0;
    logic hit;

    int checks = 0;
    int errors = 0;
    int run_cnt = 0;      // bench model: qualified ones in the current run
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;  // 125 MHz

    ones_run_detect dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_in  (bit_in),
        .bit_vld (bit_vld),
        .hit     (hit)
    );

    // Standalone next-state logic, driven directly to reach the unused code (R7)
    logic [1:0] probe_cs;
    logic       probe_din;
    logic [1:0] probe_ns;
    ones_run_next ns_probe_i (
        .cs_i  (probe_cs),
        .din_i (probe_din),
        .vld_i (1'b1),
        .ns_o  (probe_ns)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one bit, push the expected flag from the bench model
    task automatic drive(input bit d, input bit v, input string tag);
        bit e;
        @(negedge clk);
        bit_in  = d;
        bit_vld = v;
        e = v && d && (run_cnt == 2);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (v) begin
            if (!d)               run_cnt = 0;
            else if (run_cnt == 2) run_cnt = 0;
            else                  run_cnt++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        bit_vld = 1'b0;
        bit_in  = 1'b0;
        @(negedge clk);
        rst_n   = 1'b1;
        run_cnt = 0;
    endtask

    // Monitor: compare the flag mid-cycle against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, int'(hit), int'(e));
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: after reset the first two ones do not flag
        #2 check("R1 idle flag", int'(hit), 0);
        drive(1, 1, "R1 first one");
        drive(1, 1, "R1 second one");
        drive(1, 1, "R4 third one");
        // R4: six ones -> flags on third and sixth
        for (int i = 0; i < 6; i++) drive(1, 1, "R4 six ones");
        // R2: a zero breaks the run
        drive(1, 1, "R3 one");
        drive(1, 1, "R3 two");
        drive(0, 1, "R2 zero after two");
        drive(1, 1, "R2 restart 1");
        drive(1, 1, "R2 restart 2");
        drive(1, 1, "R2 restart 3");
        // R6: unqualified cycles hold the count
        drive(1, 1, "R6 q1");
        drive(1, 0, "R6 invalid one");
        drive(1, 1, "R6 q2");
        drive(0, 0, "R6 invalid zero");
        drive(1, 0, "R6 invalid one at two-seen");
        drive(1, 1, "R6 q3 flags");
        // R5: zeros and mixed patterns never flag spuriously
        drive(0, 1, "R5 zero");
        drive(1, 1, "R5 a");
        drive(0, 1, "R5 b");
        drive(1, 1, "R5 c");
        drive(1, 1, "R5 d");
        drive(0, 1, "R5 e");
        // R1: reset in the middle of a run
        drive(1, 1, "R1 pre a");
        drive(1, 1, "R1 pre b");
        do_reset();
        drive(1, 1, "R1 post 1");
        drive(1, 1, "R1 post 2");
        drive(1, 1, "R1 post 3");
        drive(0, 1, "R2 tail");
        @(negedge clk);
        @(negedge clk);
        // R7: recovery from the unused code
        probe_cs = 2'b11; probe_din = 1'b0;
        #1 check("R7 11 with 0", int'(probe_ns), 0);
        probe_din = 1'b1;
        #1 check("R7 11 with 1", int'(probe_ns), 2);
        probe_cs = 2'b00;
        #1 check("R7 00 with 1", int'(probe_ns), 1);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule